// File: doc/BRIEF.md
# Machine Cycle Bus Sequencer

This block sequences the external bus for a very small accumulator CPU. Work is split into machine cycles of three clock periods each, and FETCH cycles alternate with EXECUTE cycles. The address goes out in period 1 together with an address-latch strobe. Period 2 is reserved for advancing the program counter. Period 3 carries the read or write strobe, and the data transfer completes on the clock edge that closes it.

A FETCH cycle puts the program counter on the address bus and captures the instruction byte. An EXECUTE cycle puts the instruction's operand address on the bus and performs the operation at the end of period 3. Jump and stop execute cycles leave period 2 idle. After a stop the bus goes quiet until the next reset. An instruction byte holds a 4-bit opcode in bits 7:4 and a 4-bit address in bits 3:0. Because both cycles advance the counter, instructions occupy even addresses and odd addresses are free for data.

Top module: `mcs_seq`

## Requirements
- R1: While `rst` is high (synchronous, active high), `ale`, `rd` and `wr` are low and `pc`, `acc` and `halted` are 0. The first period after release is FETCH period 1, with `ale` high, `bus_addr` = 0 and `in_execute` low.
- R2: Every machine cycle lasts exactly three clock periods. FETCH and EXECUTE cycles alternate, and `ale` is high in period 1 only, for one clock.
- R3: In period 3 of every machine cycle exactly one of `rd` and `wr` is high. `wr` is high only in a store EXECUTE cycle, and neither strobe is high in periods 1 or 2.
- R4: During a FETCH cycle `bus_addr` equals `pc`. The counter advances by one (modulo 16) at the edge that ends FETCH period 2, and the instruction byte is captured at the edge that ends period 3.
- R5: At the edge that ends EXECUTE period 2, `pc` advances by one, except for jump (opcode 4) and stop (opcode 5). For those two, period 2 is a dummy and `pc` is unchanged.
- R6: During an EXECUTE cycle `bus_addr` equals the operand field, bits 3:0 of the captured instruction.
- R7: `exec_now` is high exactly in EXECUTE period 3, and the operation takes effect on the edge that ends it. Load (opcode 1) copies `bus_rdata` into `acc`. Add (opcode 3) sets `acc` to `acc` + `bus_rdata` modulo 256. Store (opcode 2) drives `acc` on `bus_wdata` while `wr` is high.
- R8: A jump sets `pc` to the operand at the end of EXECUTE period 3, so the next FETCH presents the jump target.
- R9: A stop sets `halted`. From then on `ale`, `rd` and `wr` stay low and `pc` and `acc` hold until reset.
- R10: The remaining opcodes (0, 6 to 15) run a normal EXECUTE cycle with a read and a counter increment, and leave `acc` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rdata | input | 8 | Data read from memory |
| bus_addr | output | 4 | Memory address, stable for the whole machine cycle |
| ale | output | 1 | Address latch strobe, period 1 |
| rd | output | 1 | Read strobe, period 3 |
| wr | output | 1 | Write strobe, period 3 of a store |
| bus_wdata | output | 8 | Write data, the accumulator while `wr` is high, else 0 |
| exec_now | output | 1 | Datapath execute strobe |
| in_execute | output | 1 | High during EXECUTE cycles |
| pc | output | 4 | Program counter |
| acc | output | 8 | Accumulator |
| halted | output | 1 | A stop has been executed |

## Verification
The bench runs four short programs against a period-by-period reference model and compares strobe positions, address, counter and accumulator on every clock. A load/add/store program with a carry out of bit 7 separates read from write cycles and shows modulo arithmetic. A jump program that also contains unused opcodes separates dummy periods from incrementing ones and shows that unused opcodes leave the accumulator alone. A loop that jumps to address 14 makes the counter wrap from 15 to 0, and an immediate stop shows that the bus stays quiet after a halt.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int OP_W = 4;

  typedef enum logic [1:0] {PER1 = 2'd0, PER2 = 2'd1, PER3 = 2'd2} period_e;

  localparam logic [OP_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OP_W-1:0] OP_STORE = 4'h2;
  localparam logic [OP_W-1:0] OP_ADD   = 4'h3;
  localparam logic [OP_W-1:0] OP_JUMP  = 4'h4;
  localparam logic [OP_W-1:0] OP_STOP  = 4'h5;

  // Opcodes whose execute cycle leaves period 2 idle
  function automatic logic needs_dummy(input logic [OP_W-1:0] op);
    return (op == OP_JUMP) || (op == OP_STOP);
  endfunction

  function automatic logic writes_mem(input logic [OP_W-1:0] op);
    return op == OP_STORE;
  endfunction
endpackage

// File: rtl/mcs_phase.sv
module mcs_phase
  import mcs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic in_exec,
  output logic p1,
  output logic p2,
  output logic p3
);
  period_e per_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q   <= PER1;
      in_exec <= 1'b0;
    end else if (!hold) begin
      case (per_q)
        PER1:    per_q <= PER2;
        PER2:    per_q <= PER3;
        default: begin
          per_q   <= PER1;
          in_exec <= ~in_exec;
        end
      endcase
    end
  end

  assign p1 = (per_q == PER1);
  assign p2 = (per_q == PER2);
  assign p3 = (per_q == PER3);
endmodule

// File: rtl/mcs_pcnt.sv
module mcs_pcnt #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          load,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] pc_d
);
  always_comb begin
    if (load)     pc_d = target;
    else if (inc) pc_d = pc_q + 1'b1;
    else          pc_d = pc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_d;
  end
endmodule

// File: rtl/mcs_core.sv
module mcs_core
  import mcs_pkg::*;
#(
  parameter int AW = 4,
  localparam int DW = OP_W + AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ir_load,
  input  logic            exec_now,
  input  logic [DW-1:0]   rdata,
  output logic [OP_W-1:0] op,
  output logic [AW-1:0]   opnd,
  output logic [DW-1:0]   acc_q,
  output logic            halted_q
);
  logic [DW-1:0] ir_q;

  assign op   = ir_q[DW-1:AW];
  assign opnd = ir_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q     <= '0;
      acc_q    <= '0;
      halted_q <= 1'b0;
    end else begin
      if (ir_load) ir_q <= rdata;
      if (exec_now) begin
        case (op)
          OP_LOAD: acc_q    <= rdata;
          OP_ADD:  acc_q    <= acc_q + rdata;
          OP_STOP: halted_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mcs_seq.sv
module mcs_seq
  import mcs_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DATA_W = OP_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              ale,
  output logic              rd,
  output logic              wr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              exec_now,
  output logic              in_execute,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc,
  output logic              halted
);
  logic p1, p2, p3;
  logic active;
  logic [OP_W-1:0] op;
  logic [ADDR_W-1:0] opnd;
  logic [ADDR_W-1:0] pc_d;
  logic pc_inc, pc_load, ir_load, wr_cycle;
  logic [ADDR_W-1:0] addr_q;

  mcs_phase u_phase (
    .clk(clk), .rst(rst), .hold(halted),
    .in_exec(in_execute), .p1(p1), .p2(p2), .p3(p3)
  );

  assign active   = !rst && !halted;
  assign exec_now = p3 && in_execute && active;
  assign ir_load  = p3 && !in_execute && active;
  assign pc_inc   = p2 && !halted && !(in_execute && needs_dummy(op));
  assign pc_load  = exec_now && (op == OP_JUMP);
  assign wr_cycle = in_execute && writes_mem(op);

  mcs_pcnt #(.AW(ADDR_W)) u_pc (
    .clk(clk), .rst(rst), .inc(pc_inc), .load(pc_load),
    .target(opnd), .pc_q(pc), .pc_d(pc_d)
  );

  mcs_core #(.AW(ADDR_W)) u_core (
    .clk(clk), .rst(rst), .ir_load(ir_load), .exec_now(exec_now),
    .rdata(bus_rdata), .op(op), .opnd(opnd),
    .acc_q(acc), .halted_q(halted)
  );

  // Address register: reloaded as each machine cycle begins
  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else if (p3 && !halted)
      addr_q <= in_execute ? pc_d : bus_rdata[ADDR_W-1:0];
  end

  assign bus_addr  = addr_q;
  assign ale       = p1 && active;
  assign rd        = p3 && active && !wr_cycle;
  assign wr        = p3 && active && wr_cycle;
  assign bus_wdata = wr ? acc : '0;
endmodule

// File: rtl/mcs_seq_chk.sv
module mcs_seq_chk
  import mcs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ale,
  input logic              rd,
  input logic              wr,
  input logic              halted,
  input logic              in_execute,
  input logic              p1,
  input logic              p2,
  input logic              p3,
  input logic [OP_W-1:0]   op,
  input logic [ADDR_W-1:0] opnd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [ADDR_W-1:0] pc
);
  a_r2_ale_in_p1: assert property (@(posedge clk) disable iff (rst) ale |-> p1);
  a_r2_ale_single: assert property (@(posedge clk) disable iff (rst) ale |=> !ale);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst) !(rd && wr));
  a_r3_strobe_p3: assert property (@(posedge clk) disable iff (rst) (rd || wr) |-> p3);
  a_r3_after_ale: assert property (@(posedge clk) disable iff (rst) ale |=> ##1 (rd || wr));
  a_r4_fetch_addr: assert property (@(posedge clk) disable iff (rst)
    (ale && !in_execute) |-> (bus_addr == pc));
  a_r4_fetch_inc: assert property (@(posedge clk) disable iff (rst)
    (p2 && !in_execute && !halted) |=> (pc == ADDR_W'($past(pc) + 1'b1)));
  a_r5_dummy_hold: assert property (@(posedge clk) disable iff (rst)
    (p2 && in_execute && !halted && (op == OP_JUMP || op == OP_STOP)) |=> $stable(pc));
  a_r6_exec_addr: assert property (@(posedge clk) disable iff (rst)
    (ale && in_execute) |-> (bus_addr == opnd));
  a_r9_quiet: assert property (@(posedge clk) disable iff (rst) halted |-> !(ale || rd || wr));
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst) halted |=> halted);
  a_r9_pc_frozen: assert property (@(posedge clk) disable iff (rst) halted |=> $stable(pc));
endmodule

bind mcs_seq mcs_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ale(ale), .rd(rd), .wr(wr), .halted(halted),
  .in_execute(in_execute), .p1(p1), .p2(p2), .p3(p3), .op(op), .opnd(opnd),
  .bus_addr(bus_addr), .pc(pc)
);

// File: tb/sim_mcs_seq.sv
`timescale 1ns/1ps
module sim_mcs_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] bus_rdata, bus_wdata, acc;
  logic [3:0] bus_addr, pc;
  logic ale, rd, wr, exec_now, in_execute, halted;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [7:0] mem [16];
  logic [7:0] mref [16];

  // reference model state
  int         m_per;
  bit         m_exec, m_halt;
  logic [3:0] m_pc, m_addr;
  logic [7:0] m_acc, m_ir;

  always #2.5 clk = ~clk;

  mcs_seq u0 (
    .clk(clk), .rst(rst), .bus_rdata(bus_rdata), .bus_addr(bus_addr),
    .ale(ale), .rd(rd), .wr(wr), .bus_wdata(bus_wdata), .exec_now(exec_now),
    .in_execute(in_execute), .pc(pc), .acc(acc), .halted(halted)
  );

  assign bus_rdata = mem[bus_addr];
  always @(posedge clk) if (wr) mem[bus_addr] <= bus_wdata;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'h00;
      mref[i] = 8'h00;
    end
  endtask

  task automatic put(input int a, input logic [7:0] v);
    mem[a] = v;
    mref[a] = v;
  endtask

  // R1: reset state, then release into FETCH period 1
  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "ale in reset", ale, 0);
    check("R1", "rd/wr in reset", {rd, wr}, 0);
    check("R1", "pc in reset", pc, 0);
    check("R1", "acc in reset", acc, 0);
    check("R1", "halted in reset", halted, 0);
    rst = 1'b0;
    m_per = 1; m_exec = 0; m_halt = 0;
    m_pc = 0; m_addr = 0; m_acc = 0; m_ir = 0;
    #1;
    check("R1", "ale after release", ale, 1);
    check("R1", "addr after release", bus_addr, 0);
    check("R1", "in_execute after release", in_execute, 0);
  endtask

  // Compare all outputs with the model in the current period
  task automatic compare();
    logic act, e_wr, e_rd;
    act  = !m_halt;
    e_wr = act && m_per == 3 && m_exec && m_ir[7:4] == 4'h2;
    e_rd = act && m_per == 3 && !e_wr;
    check("R2", "ale", ale, act && m_per == 1);
    check("R3", "rd", rd, e_rd);
    check("R3", "wr", wr, e_wr);
    check("R7", "exec_now", exec_now, act && m_per == 3 && m_exec);
    check("R4", "pc", pc, m_pc);
    check("R7", "acc", acc, m_acc);
    check("R9", "halted", halted, m_halt);
    if (act) check("R2", "in_execute", in_execute, m_exec);
    if (act && m_per == 1) check(m_exec ? "R6" : "R4", "addr", bus_addr, m_addr);
    if (e_wr) check("R7", "wdata", bus_wdata, m_acc);
  endtask

  task automatic model_step();
    logic [7:0] d;
    logic [3:0] op;
    if (m_halt) return;
    d  = mref[m_addr];
    op = m_ir[7:4];
    if (m_per == 1) m_per = 2;
    else if (m_per == 2) begin
      if (!m_exec || !(op == 4'h4 || op == 4'h5)) m_pc = m_pc + 1;  // R5 dummy
      m_per = 3;
    end else begin
      if (!m_exec) begin
        m_ir = d; m_addr = d[3:0]; m_exec = 1;
      end else begin
        case (op)
          4'h1: m_acc = d;
          4'h3: m_acc = m_acc + d;
          4'h2: mref[m_addr] = m_acc;
          4'h4: m_pc = m_ir[3:0];
          4'h5: m_halt = 1;
          default: ;
        endcase
        m_exec = 0; m_addr = m_pc;
      end
      m_per = 1;
    end
  endtask

  task automatic run_cmp(input int n);
    for (int i = 0; i < n; i++) begin
      compare();
      model_step();
      @(negedge clk);
      #1;
    end
  endtask

  // R7, R3, R9: load, add with carry out, store, stop
  task automatic t_arith();
    clear_mem();
    put(0, 8'h19); put(2, 8'h3A); put(4, 8'h2B); put(6, 8'h50);
    put(9, 8'h25); put(10, 8'hF0);
    do_reset();
    run_cmp(34);
    check("R7", "acc after add wrap", acc, 8'h15);
    check("R7", "stored byte", mem[11], 8'h15);
    check("R9", "halted after stop", halted, 1);
    check("R5", "pc after stop dummy", pc, 4'h7);
  endtask

  // R8, R10: jump over code, unused opcodes
  task automatic t_jump();
    clear_mem();
    put(0, 8'h48); put(2, 8'h13); put(3, 8'hAA);
    put(8, 8'h7D); put(10, 8'h1C); put(12, 8'h66); put(14, 8'h50);
    do_reset();
    run_cmp(38);
    check("R8", "skipped load not done / final acc", acc, 8'h66);
    check("R10", "pc after unused ops", pc, 4'hF);
    check("R9", "halted", halted, 1);
  endtask

  // R4: counter wraps from 15 to 0 inside a loop
  task automatic t_wrap();
    clear_mem();
    put(0, 8'h4E); put(14, 8'h3F); put(15, 8'h01);
    do_reset();
    run_cmp(40);
    check("R4", "acc after three loops", acc, 8'h03);
    check("R9", "not halted", halted, 0);
  endtask

  // R9: immediate stop keeps bus quiet
  task automatic t_halt();
    clear_mem();
    put(0, 8'h50);
    do_reset();
    run_cmp(26);
    check("R9", "pc frozen", pc, 4'h1);
    check("R9", "strobes quiet", {ale, rd, wr}, 0);
  endtask

  initial begin
    t_arith();
    t_jump();
    t_wrap();
    t_halt();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule